// File: doc/BRIEF.md
# Multiprocessor Interrupt Mask Controller

This block merges a set of hardware interrupt request lines and a small bank of software interrupt bits into one shared status word. The status word always shows the raw, live state of every request. Each of four processors has its own enable mask over that word, and each processor gets one interrupt output. The output is asserted when any request that is live in the status word is also enabled in that processor's mask.

A simple register bus gives read access to the status word and read/write access to the four enable masks. Software interrupts are raised through a dedicated write-1-to-set port and lowered through a separate write-1-to-clear port. Neither port stores any value of its own. Two reset inputs, a system reset and a local reset, each clear the enable masks and the software bits. The hardware request bits in the status word are never touched by reset, so they remain visible while either reset is held.

The block has no sequencing state beyond its registers: the software bit bank, the enable bank and the output stage are plain registered datapaths.

Top module: `irq_mask_ctrl`

## Requirements
- R1: Reading bus address 0 returns the status word: bits 3..0 are the software interrupt bits, bits 11..4 follow `hw_req[7:0]` in the same cycle, and bits 15..12 read 0.
- R2: Bus addresses 1 to 4 hold the enable masks of processors 0 to 3. A write stores data bits 11..0, and a read returns the stored bits with bits 15..12 read as 0.
- R3: A cycle with `sys_rst` or `loc_rst` high clears all four enable masks to 0.
- R4: A cycle with `swi_set_valid` high sets each software bit whose `swi_set_mask` bit is 1 and leaves the other software bits unchanged.
- R5: A cycle with `swi_clr_valid` high clears each software bit whose `swi_clr_mask` bit is 1 and leaves the other software bits unchanged.
- R6: If the same software bit is both set and cleared in one cycle, the bit ends up set.
- R7: Either reset clears the software bits, while the hardware request bits of the status word keep following `hw_req` during and after reset.
- R8: `cpu_irq[k]` equals, one clock later, the OR of (status bits 11..0 AND enable mask k). It is 0 while reset is held.
- R9: Bus writes to address 0 or to addresses 5 to 7 change no stored state, and reads of addresses 5 to 7 return 0.
- R10: The status word does not depend on any enable mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| sys_rst | input | 1 | System reset, active high, synchronous |
| loc_rst | input | 1 | Local reset, active high, synchronous |
| hw_req | input | 8 | Hardware interrupt request lines, active high |
| bus_we | input | 1 | Bus write strobe |
| bus_addr | input | 3 | Bus register address |
| bus_wdata | input | 16 | Bus write data |
| bus_rdata | output | 16 | Bus read data (combinational from address) |
| swi_set_valid | input | 1 | Software interrupt set strobe |
| swi_set_mask | input | 4 | Software bits to set |
| swi_clr_valid | input | 1 | Software interrupt clear strobe |
| swi_clr_mask | input | 4 | Software bits to clear |
| cpu_irq | output | 4 | Registered interrupt output, one per processor |

## Verification
The masking function is tried with a table of request patterns in which each row raises a different mix of software and hardware bits. This includes rows with only software bits, only hardware bits, a single high-order hardware line, and everything set. These rows run against four enable masks chosen so that each processor watches a different slice of the word: all software bits, all hardware bits, one hardware line, and one software bit. A wrong bit position, a swapped mask or a missing OR term therefore shows up on a different output. Directed cases separate the two resets from each other and check a set and a clear of the same bit in one cycle. They also confirm that hardware bits are visible while a reset is held, and that writes to read-only and unmapped addresses leave the stored state unchanged.

// File: rtl/irq_mask_pkg.sv
package irq_mask_pkg;

    localparam int DEF_WORD_W = 16;
    localparam int DEF_NUM_SW = 4;
    localparam int DEF_NUM_HW = 8;
    localparam int DEF_NUM_CPU = 4;
    localparam int DEF_ADDR_W = 3;

    // bus address of the status word; enable mask k sits at STAT_ADDR + 1 + k
    localparam int STAT_ADDR = 0;

endpackage

// File: rtl/irq_swi_bank.sv
module irq_swi_bank #(
    parameter int NUM_SW = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              set_valid,
    input  logic [NUM_SW-1:0] set_mask,
    input  logic              clr_valid,
    input  logic [NUM_SW-1:0] clr_mask,
    output logic [NUM_SW-1:0] swi_q
);

    logic [NUM_SW-1:0] set_eff;
    logic [NUM_SW-1:0] clr_eff;
    logic [NUM_SW-1:0] swi_d;

    always_comb begin
        set_eff = set_valid ? set_mask : '0;
        clr_eff = clr_valid ? clr_mask : '0;
        // set is applied after clear so it wins on a collision
        swi_d   = (swi_q & ~clr_eff) | set_eff;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            swi_q <= '0;
        end else begin
            swi_q <= swi_d;
        end
    end

endmodule

// File: rtl/irq_enable_bank.sv
module irq_enable_bank #(
    parameter int NUM_CPU = 4,
    parameter int LIVE_W  = 12
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NUM_CPU-1:0]        wr_en,
    input  logic [LIVE_W-1:0]         wdata,
    output logic [NUM_CPU*LIVE_W-1:0] en_flat
);

    for (genvar k = 0; k < NUM_CPU; k++) begin : g_mask
        logic [LIVE_W-1:0] mask_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                mask_q <= '0;
            end else if (wr_en[k]) begin
                mask_q <= wdata;
            end
        end

        assign en_flat[k*LIVE_W +: LIVE_W] = mask_q;
    end

endmodule

// File: rtl/irq_out_stage.sv
module irq_out_stage #(
    parameter int NUM_CPU = 4,
    parameter int LIVE_W  = 12
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [LIVE_W-1:0]         live,
    input  logic [NUM_CPU*LIVE_W-1:0] en_flat,
    output logic [NUM_CPU-1:0]        cpu_irq
);

    for (genvar k = 0; k < NUM_CPU; k++) begin : g_cpu
        logic hit;

        assign hit = |(live & en_flat[k*LIVE_W +: LIVE_W]);

        always_ff @(posedge clk) begin
            if (rst) begin
                cpu_irq[k] <= 1'b0;
            end else begin
                cpu_irq[k] <= hit;
            end
        end
    end

endmodule

// File: rtl/irq_mask_ctrl.sv
module irq_mask_ctrl
    import irq_mask_pkg::*;
#(
    parameter int WORD_W  = DEF_WORD_W,
    parameter int NUM_SW  = DEF_NUM_SW,
    parameter int NUM_HW  = DEF_NUM_HW,
    parameter int NUM_CPU = DEF_NUM_CPU,
    parameter int ADDR_W  = DEF_ADDR_W
) (
    input  logic              clk,
    input  logic              sys_rst,
    input  logic              loc_rst,
    input  logic [NUM_HW-1:0] hw_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic              swi_set_valid,
    input  logic [NUM_SW-1:0] swi_set_mask,
    input  logic              swi_clr_valid,
    input  logic [NUM_SW-1:0] swi_clr_mask,
    output logic [NUM_CPU-1:0] cpu_irq
);

    localparam int LIVE_W = NUM_SW + NUM_HW;

    logic                      rst;
    logic [NUM_SW-1:0]         swi_q;
    logic [LIVE_W-1:0]         live;
    logic [WORD_W-1:0]         status;
    logic [NUM_CPU-1:0]        en_wr;
    logic [NUM_CPU*LIVE_W-1:0] en_flat;

    assign rst    = sys_rst | loc_rst;
    assign live   = {hw_req, swi_q};
    assign status = WORD_W'(live);

    for (genvar k = 0; k < NUM_CPU; k++) begin : g_wdec
        assign en_wr[k] = bus_we && (bus_addr == ADDR_W'(STAT_ADDR + 1 + k));
    end

    irq_swi_bank #(
        .NUM_SW(NUM_SW)
    ) u_swi (
        .clk      (clk),
        .rst      (rst),
        .set_valid(swi_set_valid),
        .set_mask (swi_set_mask),
        .clr_valid(swi_clr_valid),
        .clr_mask (swi_clr_mask),
        .swi_q    (swi_q)
    );

    irq_enable_bank #(
        .NUM_CPU(NUM_CPU),
        .LIVE_W (LIVE_W)
    ) u_en (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (en_wr),
        .wdata  (bus_wdata[LIVE_W-1:0]),
        .en_flat(en_flat)
    );

    irq_out_stage #(
        .NUM_CPU(NUM_CPU),
        .LIVE_W (LIVE_W)
    ) u_out (
        .clk    (clk),
        .rst    (rst),
        .live   (live),
        .en_flat(en_flat),
        .cpu_irq(cpu_irq)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(STAT_ADDR)) begin
            bus_rdata = status;
        end else begin
            for (int k = 0; k < NUM_CPU; k++) begin
                if (bus_addr == ADDR_W'(STAT_ADDR + 1 + k)) begin
                    bus_rdata = WORD_W'(en_flat[k*LIVE_W +: LIVE_W]);
                end
            end
        end
    end

endmodule

// File: rtl/irq_mask_ctrl_chk.sv
module irq_mask_ctrl_chk #(
    parameter int WORD_W  = 16,
    parameter int NUM_SW  = 4,
    parameter int NUM_HW  = 8,
    parameter int NUM_CPU = 4,
    parameter int ADDR_W  = 3
) (
    input logic                             clk,
    input logic                             sys_rst,
    input logic                             loc_rst,
    input logic [NUM_HW-1:0]                hw_req,
    input logic                             bus_we,
    input logic [ADDR_W-1:0]                bus_addr,
    input logic [WORD_W-1:0]                bus_rdata,
    input logic                             swi_set_valid,
    input logic [NUM_SW-1:0]                swi_set_mask,
    input logic                             swi_clr_valid,
    input logic [NUM_SW-1:0]                swi_clr_mask,
    input logic [NUM_SW-1:0]                swi_q,
    input logic [NUM_CPU*(NUM_SW+NUM_HW)-1:0] en_flat,
    input logic [NUM_CPU-1:0]               cpu_irq
);

    localparam int LIVE_W = NUM_SW + NUM_HW;

    logic rst_any;
    assign rst_any = sys_rst | loc_rst;

    // R1: reserved status bits read 0, hardware bits track the request lines
    p_status_layout_r1: assert property (@(posedge clk) disable iff (rst_any)
        (bus_addr == '0) |->
            (bus_rdata[WORD_W-1:LIVE_W] == '0) && (bus_rdata[LIVE_W-1:NUM_SW] == hw_req));

    // R3: after a reset cycle the outputs stay low one more cycle (masks empty)
    p_mask_cleared_r3: assert property (@(posedge clk) disable iff (rst_any)
        $past(rst_any) |=> (cpu_irq == '0));

    // R4 and R6: requested set bits are high in the next cycle
    p_swi_set_r4: assert property (@(posedge clk) disable iff (rst_any)
        swi_set_valid |=> ((swi_q & $past(swi_set_mask)) == $past(swi_set_mask)));

    // R5: cleared bits are low in the next cycle when no set collides
    p_swi_clr_r5: assert property (@(posedge clk) disable iff (rst_any)
        (swi_clr_valid && !swi_set_valid) |=> ((swi_q & $past(swi_clr_mask)) == '0));

    // R8: an output can only rise when something in the live word was set
    p_irq_source_r8: assert property (@(posedge clk) disable iff (rst_any)
        (cpu_irq != '0) |-> ($past(swi_q) != '0 || $past(hw_req) != '0));

    // R9: writes to non-mask addresses leave the masks untouched
    p_unmapped_write_r9: assert property (@(posedge clk) disable iff (rst_any)
        (bus_we && (bus_addr == '0 || bus_addr > ADDR_W'(NUM_CPU))) |=> $stable(en_flat));

    // R9: unmapped reads return 0
    p_unmapped_read_r9: assert property (@(posedge clk) disable iff (rst_any)
        (bus_addr > ADDR_W'(NUM_CPU)) |-> (bus_rdata == '0));

endmodule

bind irq_mask_ctrl irq_mask_ctrl_chk #(
    .WORD_W (WORD_W),
    .NUM_SW (NUM_SW),
    .NUM_HW (NUM_HW),
    .NUM_CPU(NUM_CPU),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk          (clk),
    .sys_rst      (sys_rst),
    .loc_rst      (loc_rst),
    .hw_req       (hw_req),
    .bus_we       (bus_we),
    .bus_addr     (bus_addr),
    .bus_rdata    (bus_rdata),
    .swi_set_valid(swi_set_valid),
    .swi_set_mask (swi_set_mask),
    .swi_clr_valid(swi_clr_valid),
    .swi_clr_mask (swi_clr_mask),
    .swi_q        (swi_q),
    .en_flat      (en_flat),
    .cpu_irq      (cpu_irq)
);

// File: tb/sim_irq_mask_ctrl.sv
`timescale 1ns/1ps
module sim_irq_mask_ctrl;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        sys_rst = 1'b1;
    logic        loc_rst = 1'b0;
    logic [7:0]  hw_req = '0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        swi_set_valid = 1'b0;
    logic [3:0]  swi_set_mask = '0;
    logic        swi_clr_valid = 1'b0;
    logic [3:0]  swi_clr_mask = '0;
    logic [3:0]  cpu_irq;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_mask_ctrl u0 (
        .clk(clk), .sys_rst(sys_rst), .loc_rst(loc_rst), .hw_req(hw_req),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .swi_set_valid(swi_set_valid), .swi_set_mask(swi_set_mask),
        .swi_clr_valid(swi_clr_valid), .swi_clr_mask(swi_clr_mask),
        .cpu_irq(cpu_irq)
    );

    // enable masks used by the table: swi only, hw only, hw line 0, swi bit 3
    localparam logic [11:0] MASK [0:3] = '{12'h00F, 12'hFF0, 12'h010, 12'h008};

    // {hw_req, set mask, expected status}
    localparam logic [27:0] VEC [0:7] = '{
        28'h00_0_0000, 28'h00_1_0001, 28'h01_0_0010, 28'h80_8_0808,
        28'hFF_F_0FFF, 28'h02_4_0024, 28'h10_0_0100, 28'h00_8_0008
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    function automatic logic [3:0] expect_irq(input logic [15:0] st);
        logic [3:0] r;
        for (int k = 0; k < 4; k++) r[k] = |(st[11:0] & MASK[k]);
        return r;
    endfunction

    initial begin
        #(CLK_PERIOD * 100000);
        bad++;
        $display("FAIL watchdog act=timeout exp=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] d;
        logic [15:0] st;
        repeat (3) @(negedge clk);
        // reset state
        chk("R8 reset irq", 32'(cpu_irq), 0);
        sys_rst = 1'b0;
        @(negedge clk);
        rd(3'd0, d); chk("R1 reset status", 32'(d), 0);
        for (int k = 0; k < 4; k++) begin
            rd(3'(1 + k), d); chk("R3 reset mask", 32'(d), 0);
        end

        // R2: masks written with all ones read back with reserved bits 0
        wr(3'd1, 16'hFFFF);
        rd(3'd1, d); chk("R2 mask readback", 32'(d), 32'h0FFF);
        for (int k = 0; k < 4; k++) wr(3'(1 + k), {4'hF, MASK[k]});
        for (int k = 0; k < 4; k++) begin
            rd(3'(1 + k), d); chk("R2 mask value", 32'(d), 32'(MASK[k]));
        end

        // table walk: R1, R4, R5, R8, R10
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            hw_req = VEC[i][27:20];
            swi_clr_valid = 1'b1; swi_clr_mask = 4'hF;
            @(negedge clk);
            swi_clr_valid = 1'b0;
            swi_set_valid = 1'b1; swi_set_mask = VEC[i][19:16];
            @(negedge clk);
            swi_set_valid = 1'b0;
            rd(3'd0, st); chk("R1 R4 R5 status", 32'(st), 32'(VEC[i][15:0]));
            @(negedge clk);
            chk("R8 cpu_irq", 32'(cpu_irq), 32'(expect_irq(VEC[i][15:0])));
        end

        // R4: set leaves other bits alone; R5: clear leaves other bits alone
        hw_req = '0;
        @(negedge clk); swi_set_valid = 1'b1; swi_set_mask = 4'h1;
        @(negedge clk); swi_set_mask = 4'h4;
        @(negedge clk); swi_set_valid = 1'b0;
        rd(3'd0, d); chk("R4 accumulate", 32'(d), 32'h000D);
        @(negedge clk); swi_clr_valid = 1'b1; swi_clr_mask = 4'h4;
        @(negedge clk); swi_clr_valid = 1'b0;
        rd(3'd0, d); chk("R5 partial clear", 32'(d), 32'h0009);

        // R6: same bit set and cleared together stays set
        @(negedge clk);
        swi_set_valid = 1'b1; swi_set_mask = 4'h2;
        swi_clr_valid = 1'b1; swi_clr_mask = 4'hF;
        @(negedge clk);
        swi_set_valid = 1'b0; swi_clr_valid = 1'b0;
        rd(3'd0, d); chk("R6 set wins", 32'(d), 32'h0002);

        // R10: changing masks does not touch status
        wr(3'd2, 16'h0000);
        rd(3'd0, d); chk("R10 status vs mask", 32'(d), 32'h0002);
        wr(3'd2, {4'h0, MASK[1]});

        // R9: writes to status and unmapped addresses ignored
        wr(3'd0, 16'hFFFF);
        wr(3'd5, 16'hFFFF);
        wr(3'd7, 16'hFFFF);
        rd(3'd0, d); chk("R9 status write ignored", 32'(d), 32'h0002);
        for (int k = 0; k < 4; k++) begin
            rd(3'(1 + k), d); chk("R9 masks kept", 32'(d), 32'(MASK[k]));
        end
        rd(3'd6, d); chk("R9 unmapped read", 32'(d), 0);

        // R7: local reset clears swi, hw bits stay visible during reset
        hw_req = 8'h5A;
        @(negedge clk); swi_set_valid = 1'b1; swi_set_mask = 4'h3;
        @(negedge clk); swi_set_valid = 1'b0; loc_rst = 1'b1;
        @(negedge clk);
        rd(3'd0, d); chk("R7 status in reset", 32'(d), 32'h05A0);
        chk("R8 irq in reset", 32'(cpu_irq), 0);
        @(negedge clk); loc_rst = 1'b0;
        for (int k = 0; k < 4; k++) begin
            rd(3'(1 + k), d); chk("R3 loc_rst mask", 32'(d), 0);
        end

        // R3: system reset alone also clears masks and swi
        hw_req = '0;
        wr(3'd4, 16'h0ABC);
        @(negedge clk); swi_set_valid = 1'b1; swi_set_mask = 4'h8;
        @(negedge clk); swi_set_valid = 1'b0; sys_rst = 1'b1;
        @(negedge clk); sys_rst = 1'b0;
        rd(3'd4, d); chk("R3 sys_rst mask", 32'(d), 0);
        rd(3'd0, d); chk("R7 sys_rst swi", 32'(d), 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule